// File: doc/BRIEF.md
# Floating-Point Coprocessor Instruction Decoder

This block classifies a 32-bit coprocessor instruction word for a small double-precision floating-point subset. It returns an operation code, an undefined-instruction flag, and every register field the execution side needs. The subset covers the four double arithmetic operations and a double compare. It also covers conversion between double and signed integer in both directions, and moves of one single register to or from one core register. Further, it covers moves of a pair of core registers to or from one double register, and the transfer of the comparison flags to the core status flags. A type-7 word with bit 24 set is recognised as a software trap. It is not treated as floating point.

The decoder is purely combinational and executes nothing. Single-register operands are 5-bit indices. Each is formed from a 4-bit register field, with one extra bit from elsewhere in the word appended as the least significant bit. Double registers and core registers use the raw 4-bit fields. A word whose type field (bits 27:25) is neither 6 nor 7 is not a coprocessor word. For such a word the op code is 0 and the undefined flag stays low.

Top module: `fpdec_top`

## Requirements
- R1: A word whose bits 27:25 are neither 6 nor 7 gives op code 0 (none) with undef_o low and sreg_o 0.
- R2: A word with bits 27:24 = F gives op code 1 (trap) with undef_o low, regardless of the other bits.
- R3: For type 7 with bit 24 = 0, bit 23 = 0 and bit 21 = 1, with bits 11:9 = 5, bit 8 = 1 and bit 4 = 0, bits 20/6 pick the operation: 1/0 gives code 2 (add), 1/1 gives code 3 (subtract) and 0/0 gives code 4 (multiply). The pair 0/1 is undefined.
- R4: Type 7 with bit 23 = 1, bits 21:20 = 0, bits 11:9 = 5, bit 8 = 1, bit 6 = 0 and bit 4 = 0 gives code 5 (divide).
- R5: Type 7 with bit 23 = 1, bits 21:20 = 3, bits 19:16 = 4, bits 11:9 = 5, bit 8 = 1, bit 6 = 1 and bit 4 = 0 gives code 6 (compare).
- R6: Type 7 with bit 23 = 1, bits 21:19 = 7, bits 18:16 = 5, bits 11:9 = 5, bit 8 = 1, bit 6 = 1 and bit 4 = 0 gives code 7 (double to integer). sreg_o = {bits 15:12, bit 22}.
- R7: Type 7 with bit 23 = 1, bits 21:19 = 7, bits 18:16 = 0, bits 11:9 = 5, bit 8 = 1, bits 7 and 6 = 1 and bit 4 = 0 gives code 8 (integer to double). sreg_o = {bits 3:0, bit 5}.
- R8: Type 7 with bits 23:20 = F, bits 19:16 = 1, bits 11:8 = A, bits 7:5 = 0, bit 4 = 1 and bits 3:0 = 0 gives code 13 (flag transfer) only when bits 15:12 = F. Any other value there is undefined.
- R9: Type 7 with bits 23 and 21 = 0, bits 11:8 = A, bits 6:5 = 0, bit 4 = 1 and bits 3:0 = 0 moves between one single register and one core register. Bit 20 = 1 gives code 9 (single to core) and bit 20 = 0 gives code 10 (core to single). sreg_o = {bits 19:16, bit 7}.
- R10: Bits 27:24 = C with bit 23 = 0, bit 22 = 1, bits 11:8 = B, bits 7:6 = 0 and bit 4 = 1 is a pair move. Bit 20 = 0 gives code 11 (core pair to double) and bit 20 = 1 gives code 12 (double to core pair). sreg_o = {bits 3:0, 0}, which is the lower single of the pair.
- R11: Any type-6 or type-7 word matched by none of R2 to R10 raises undef_o, with op code 0 and sreg_o 0.
- R12: The raw fields are always driven: rt_o = bits 15:12, rn_o = bits 19:16, vd_o = bits 15:12, vn_o = bits 19:16 and vm_o = bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to classify |
| op_o | output | 4 | Operation code (0 none, 1 trap, 2 to 13 as listed in the requirements) |
| undef_o | output | 1 | Coprocessor word matches no supported pattern |
| rt_o | output | 4 | First core register field |
| rn_o | output | 4 | Second core register field |
| vd_o | output | 4 | Destination double register field |
| vn_o | output | 4 | First source double register field |
| vm_o | output | 4 | Second source double register field |
| sreg_o | output | 5 | Single-register index used by the operation, or 0 |

## Verification
Each supported operation starts from one canonical encoding. The bench then flips every bit of that word singly. This separates bits that must match exactly, where a flip turns the result into another op or undefined, from operand and don't-care bits, where the op holds but sreg_o or a raw field must follow the flip. A dense sweep over bits 23:20 and 11:4 of type-7 words exercises the priority between the overlapping type-7 patterns, including the subtract/multiply hole and the flag transfer with a wrong Rt. Pseudo-random words of every type check that words outside types 6 and 7 stay silent and that unmatched coprocessor words raise undef_o.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 4;
  localparam int SIDX_W  = REG_W + 1;
  localparam int OP_W    = 4;
  localparam int SEL_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 4'd0,
    OP_TRAP   = 4'd1,
    OP_ADD    = 4'd2,
    OP_SUB    = 4'd3,
    OP_MUL    = 4'd4,
    OP_DIV    = 4'd5,
    OP_CMP    = 4'd6,
    OP_D2I    = 4'd7,
    OP_I2D    = 4'd8,
    OP_S2CORE = 4'd9,
    OP_CORE2S = 4'd10,
    OP_PAIR2D = 4'd11,
    OP_D2PAIR = 4'd12,
    OP_FLAGS  = 4'd13
  } fp_op_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE = 3'd0,
    SEL_DD   = 3'd1,
    SEL_MM   = 3'd2,
    SEL_NN   = 3'd3,
    SEL_PAIR = 3'd4
  } sidx_sel_e;

  typedef struct packed {
    fp_op_e    op;
    logic      undef;
    sidx_sel_e sel;
  } dec_res_t;

  localparam dec_res_t RES_UNDEF = '{op: OP_NONE, undef: 1'b1, sel: SEL_NONE};
  localparam dec_res_t RES_QUIET = '{op: OP_NONE, undef: 1'b0, sel: SEL_NONE};
endpackage

// File: rtl/fpdec_fields.sv
module fpdec_fields
  import fpdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic [REG_W-1:0]   rt_o,
  output logic [REG_W-1:0]   rn_o,
  output logic [REG_W-1:0]   vd_o,
  output logic [REG_W-1:0]   vn_o,
  output logic [REG_W-1:0]   vm_o,
  output logic               dx_o,
  output logic               nx_o,
  output logic               mx_o
);
  localparam int HI_LSB  = 16;
  localparam int MID_LSB = 12;
  localparam int LO_LSB  = 0;

  assign rt_o = instr_i[MID_LSB +: REG_W];
  assign vd_o = instr_i[MID_LSB +: REG_W];
  assign rn_o = instr_i[HI_LSB  +: REG_W];
  assign vn_o = instr_i[HI_LSB  +: REG_W];
  assign vm_o = instr_i[LO_LSB  +: REG_W];
  assign dx_o = instr_i[22];
  assign nx_o = instr_i[7];
  assign mx_o = instr_i[5];
endmodule

// File: rtl/fpdec_t7.sv
module fpdec_t7
  import fpdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_res_t           res_o
);
  logic dp_core;
  logic xfer_core;

  // Shared tail of the data-processing forms: bits 11:9 = 5, bit 8 = 1, bit 4 = 0
  assign dp_core   = (instr_i[11:9] == 3'd5) && instr_i[8] && !instr_i[4];
  // Shared tail of the register-transfer forms
  assign xfer_core = (instr_i[11:8] == 4'hA) && instr_i[4] && (instr_i[3:0] == 4'h0);

  always_comb begin
    res_o = RES_UNDEF;
    if (instr_i[23]) begin
      if ((instr_i[21:19] == 3'd7) && (instr_i[18:16] == 3'd5) &&
          dp_core && instr_i[6]) begin
        res_o = '{op: OP_D2I, undef: 1'b0, sel: SEL_DD};
      end else if ((instr_i[21:19] == 3'd7) && (instr_i[18:16] == 3'd0) &&
                   dp_core && instr_i[7] && instr_i[6]) begin
        res_o = '{op: OP_I2D, undef: 1'b0, sel: SEL_MM};
      end else if ((instr_i[21:20] == 2'd0) && dp_core && !instr_i[6]) begin
        res_o = '{op: OP_DIV, undef: 1'b0, sel: SEL_NONE};
      end else if ((instr_i[21:20] == 2'd3) && (instr_i[19:16] == 4'd4) &&
                   dp_core && instr_i[6]) begin
        res_o = '{op: OP_CMP, undef: 1'b0, sel: SEL_NONE};
      end else if ((instr_i[23:20] == 4'hF) && (instr_i[19:16] == 4'd1) &&
                   xfer_core && (instr_i[7:5] == 3'd0)) begin
        if (instr_i[15:12] == 4'hF) begin
          res_o = '{op: OP_FLAGS, undef: 1'b0, sel: SEL_NONE};
        end
      end
    end else if (instr_i[21]) begin
      if (dp_core) begin
        unique case ({instr_i[20], instr_i[6]})
          2'b10:   res_o = '{op: OP_ADD, undef: 1'b0, sel: SEL_NONE};
          2'b11:   res_o = '{op: OP_SUB, undef: 1'b0, sel: SEL_NONE};
          2'b00:   res_o = '{op: OP_MUL, undef: 1'b0, sel: SEL_NONE};
          default: res_o = RES_UNDEF;
        endcase
      end
    end else begin
      if (xfer_core && (instr_i[6:5] == 2'd0)) begin
        if (instr_i[20]) begin
          res_o = '{op: OP_S2CORE, undef: 1'b0, sel: SEL_NN};
        end else begin
          res_o = '{op: OP_CORE2S, undef: 1'b0, sel: SEL_NN};
        end
      end
    end
  end
endmodule

// File: rtl/fpdec_t6.sv
module fpdec_t6
  import fpdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_res_t           res_o
);
  logic pair_hit;

  assign pair_hit = (instr_i[27:24] == 4'hC) && !instr_i[23] && instr_i[22] &&
                    (instr_i[11:8] == 4'hB) && (instr_i[7:6] == 2'd0) && instr_i[4];

  always_comb begin
    res_o = RES_UNDEF;
    if (pair_hit) begin
      if (instr_i[20]) begin
        res_o = '{op: OP_D2PAIR, undef: 1'b0, sel: SEL_PAIR};
      end else begin
        res_o = '{op: OP_PAIR2D, undef: 1'b0, sel: SEL_PAIR};
      end
    end
  end
endmodule

// File: rtl/fpdec_sidx.sv
module fpdec_sidx
  import fpdec_pkg::*;
(
  input  sidx_sel_e         sel_i,
  input  logic [REG_W-1:0]  vd_i,
  input  logic [REG_W-1:0]  vn_i,
  input  logic [REG_W-1:0]  vm_i,
  input  logic              dx_i,
  input  logic              nx_i,
  input  logic              mx_i,
  output logic [SIDX_W-1:0] sidx_o
);
  always_comb begin
    unique case (sel_i)
      SEL_DD:   sidx_o = {vd_i, dx_i};
      SEL_MM:   sidx_o = {vm_i, mx_i};
      SEL_NN:   sidx_o = {vn_i, nx_i};
      SEL_PAIR: sidx_o = {vm_i, 1'b0};
      default:  sidx_o = '0;
    endcase
  end
endmodule

// File: rtl/fpdec_top.sv
module fpdec_top
  import fpdec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [3:0]  op_o,
  output logic        undef_o,
  output logic [3:0]  rt_o,
  output logic [3:0]  rn_o,
  output logic [3:0]  vd_o,
  output logic [3:0]  vn_o,
  output logic [3:0]  vm_o,
  output logic [4:0]  sreg_o
);
  localparam logic [2:0] TYPE_CP6 = 3'd6;
  localparam logic [2:0] TYPE_CP7 = 3'd7;

  logic     dx, nx, mx;
  dec_res_t res_t6, res_t7, res_sel;

  fpdec_fields u_fields (
    .instr_i (instr_i),
    .rt_o    (rt_o),
    .rn_o    (rn_o),
    .vd_o    (vd_o),
    .vn_o    (vn_o),
    .vm_o    (vm_o),
    .dx_o    (dx),
    .nx_o    (nx),
    .mx_o    (mx)
  );

  fpdec_t7 u_t7 (
    .instr_i (instr_i),
    .res_o   (res_t7)
  );

  fpdec_t6 u_t6 (
    .instr_i (instr_i),
    .res_o   (res_t6)
  );

  always_comb begin
    unique case (instr_i[27:25])
      TYPE_CP7: begin
        if (instr_i[24]) begin
          res_sel = '{op: OP_TRAP, undef: 1'b0, sel: SEL_NONE};
        end else begin
          res_sel = res_t7;
        end
      end
      TYPE_CP6: res_sel = res_t6;
      default:  res_sel = RES_QUIET;
    endcase
  end

  fpdec_sidx u_sidx (
    .sel_i  (res_sel.sel),
    .vd_i   (vd_o),
    .vn_i   (vn_o),
    .vm_i   (vm_o),
    .dx_i   (dx),
    .nx_i   (nx),
    .mx_i   (mx),
    .sidx_o (sreg_o)
  );

  assign op_o    = res_sel.op;
  assign undef_o = res_sel.undef;
endmodule

// File: rtl/fpdec_checker.sv
module fpdec_checker (
  input logic [31:0] instr_i,
  input logic [3:0]  op_o,
  input logic        undef_o,
  input logic [3:0]  rt_o,
  input logic [3:0]  vd_o,
  input logic [3:0]  vm_o,
  input logic [4:0]  sreg_o
);
  logic cop_word;
  assign cop_word = (instr_i[27:25] == 3'd6) || (instr_i[27:25] == 3'd7);

  always_comb begin
    if (!cop_word) begin
      assert_foreign_silent_R1: assert (op_o == 4'd0 && !undef_o && sreg_o == 5'd0)
        else $error("non-coprocessor word produced a decode");
    end
    if (instr_i[27:24] == 4'hF) begin
      assert_trap_R2: assert (op_o == 4'd1 && !undef_o)
        else $error("trap word not classified as trap");
    end
    if (undef_o) begin
      assert_undef_clean_R11: assert (op_o == 4'd0 && sreg_o == 5'd0)
        else $error("undefined word carries an op or index");
    end
    if (op_o == 4'd7) begin
      assert_d2i_index_R6: assert (sreg_o == {vd_o, instr_i[22]})
        else $error("double-to-integer destination index wrong");
    end
    if (op_o == 4'd11 || op_o == 4'd12) begin
      assert_pair_even_R10: assert (sreg_o == {vm_o, 1'b0} && instr_i[27:24] == 4'hC)
        else $error("pair move index not even or wrong type");
    end
    if (op_o == 4'd13) begin
      assert_flags_rt_R8: assert (rt_o == 4'hF)
        else $error("flag transfer decoded with wrong Rt");
    end
  end
endmodule

bind fpdec_top fpdec_checker u_fpdec_checker (
  .instr_i (instr_i),
  .op_o    (op_o),
  .undef_o (undef_o),
  .rt_o    (rt_o),
  .vd_o    (vd_o),
  .vm_o    (vm_o),
  .sreg_o  (sreg_o)
);

// File: tb/tb_fpdec_top.sv
module tb_fpdec_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [3:0]  op, rt, rn, vd, vn, vm;
  logic        undef;
  logic [4:0]  sreg;

  int n_chk;
  int n_bad;
  int wd_cnt;
  bit done;

  fpdec_top dut (
    .instr_i (instr),
    .op_o    (op),
    .undef_o (undef),
    .rt_o    (rt),
    .rn_o    (rn),
    .vd_o    (vd),
    .vn_o    (vn),
    .vm_o    (vm),
    .sreg_o  (sreg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference model: each pattern is a flat conjunction over the word
  task automatic ref_dec(input logic [31:0] w, output logic [3:0] e_op,
                         output logic e_un, output logic [4:0] e_ix);
    bit t7, t6, ok_dp, hit;
    t7 = (w[27:24] == 4'hE);
    t6 = (w[27:25] == 3'd6);
    ok_dp = (w[11:9] == 3'd5) && w[8] && !w[4];
    e_op = 4'd0; e_un = 1'b0; e_ix = 5'd0; hit = 1'b0;
    if (w[27:24] == 4'hF) begin e_op = 4'd1; hit = 1'b1; end
    if (t7 && w[23] && w[21:19] == 3'd7 && w[18:16] == 3'd5 && ok_dp && w[6]) begin
      e_op = 4'd7; e_ix = {w[15:12], w[22]}; hit = 1'b1; end
    if (t7 && w[23] && w[21:19] == 3'd7 && w[18:16] == 3'd0 && ok_dp && w[7] && w[6]) begin
      e_op = 4'd8; e_ix = {w[3:0], w[5]}; hit = 1'b1; end
    if (t7 && w[23] && w[21:20] == 2'd0 && ok_dp && !w[6]) begin
      e_op = 4'd5; hit = 1'b1; end
    if (t7 && w[23] && w[21:20] == 2'd3 && w[19:16] == 4'd4 && ok_dp && w[6]) begin
      e_op = 4'd6; hit = 1'b1; end
    if (t7 && w[23:20] == 4'hF && w[19:16] == 4'd1 && w[11:8] == 4'hA &&
        w[7:5] == 3'd0 && w[4] && w[3:0] == 4'd0 && w[15:12] == 4'hF) begin
      e_op = 4'd13; hit = 1'b1; end
    if (t7 && !w[23] && w[21] && ok_dp && w[20] && !w[6]) begin e_op = 4'd2; hit = 1'b1; end
    if (t7 && !w[23] && w[21] && ok_dp && w[20] && w[6])  begin e_op = 4'd3; hit = 1'b1; end
    if (t7 && !w[23] && w[21] && ok_dp && !w[20] && !w[6]) begin e_op = 4'd4; hit = 1'b1; end
    if (t7 && !w[23] && !w[21] && w[11:8] == 4'hA && w[6:5] == 2'd0 && w[4] && w[3:0] == 4'd0) begin
      e_op = w[20] ? 4'd9 : 4'd10; e_ix = {w[19:16], w[7]}; hit = 1'b1; end
    if (w[27:24] == 4'hC && !w[23] && w[22] && w[11:8] == 4'hB && w[7:6] == 2'd0 && w[4]) begin
      e_op = w[20] ? 4'd12 : 4'd11; e_ix = {w[3:0], 1'b0}; hit = 1'b1; end
    if (!hit && (t7 || t6)) e_un = 1'b1;
  endtask

  function automatic string req_of(input logic [3:0] o, input logic u);
    case (o)
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9, 4'd10: return "R9";
      4'd11, 4'd12: return "R10";
      4'd13: return "R8";
      default: return u ? "R11" : "R1";
    endcase
  endfunction

  task automatic apply_check(input logic [31:0] w);
    logic [3:0] e_op;
    logic e_un;
    logic [4:0] e_ix;
    @(negedge clk);
    instr = w;
    #1;
    ref_dec(w, e_op, e_un, e_ix);
    n_chk++;
    if (op !== e_op || undef !== e_un || sreg !== e_ix) begin
      n_bad++;
      $display("FAIL %s word=%h op/undef/sreg actual=%0d/%0b/%0d expected=%0d/%0b/%0d",
               req_of(e_op, e_un), w, op, undef, sreg, e_op, e_un, e_ix);
    end
    n_chk++; // R12 raw fields
    if (rt !== w[15:12] || rn !== w[19:16] || vd !== w[15:12] ||
        vn !== w[19:16] || vm !== w[3:0]) begin
      n_bad++;
      $display("FAIL R12 word=%h fields actual=%h,%h,%h,%h,%h expected=%h,%h,%h,%h,%h",
               w, rt, rn, vd, vn, vm, w[15:12], w[19:16], w[15:12], w[19:16], w[3:0]);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (!done) begin
      wd_cnt <= wd_cnt + 1;
      if (wd_cnt > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", wd_cnt);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  logic [31:0] bases [14];

  initial begin
    n_chk = 0; n_bad = 0; wd_cnt = 0; done = 1'b0;
    instr = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply_check(32'h0000_0000);          // reset-like idle word, R1

    bases[0]  = 32'hEE31_2B03; // add R3
    bases[1]  = 32'hEE31_2B43; // subtract R3
    bases[2]  = 32'hEE21_2B03; // multiply R3
    bases[3]  = 32'hEE81_2B03; // divide R4
    bases[4]  = 32'hEEB4_2B43; // compare R5
    bases[5]  = 32'hEEFD_2B43; // double to integer R6
    bases[6]  = 32'hEEB8_2BE3; // integer to double R7
    bases[7]  = 32'hEEF1_FA10; // flag transfer R8
    bases[8]  = 32'hEE05_7A90; // core to single R9
    bases[9]  = 32'hEE15_7A90; // single to core R9
    bases[10] = 32'hEC46_7B19; // core pair to double R10
    bases[11] = 32'hEC56_7B19; // double to core pair R10
    bases[12] = 32'hEF00_0012; // trap R2
    bases[13] = 32'hEEF1_3A10; // flag transfer, wrong Rt: R8 / R11

    for (int b = 0; b < 14; b++) begin
      apply_check(bases[b]);
      for (int k = 0; k < 32; k++) apply_check(bases[b] ^ (32'h1 << k));
    end

    // Dense sweep of type-7 selector bits 23:20 and 11:4
    for (int hi = 0; hi < 16; hi++) begin
      for (int lo = 0; lo < 256; lo++) begin
        apply_check({4'hE, 4'hE, hi[3:0], 4'h4, 4'hF, lo[7:0], 4'h0});
      end
    end

    // Pseudo-random words of every type
    begin
      logic [31:0] x;
      x = 32'h1234_5679;
      for (int r = 0; r < 3000; r++) begin
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        apply_check(x);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule